// File: doc/BRIEF.md
# E1 Common-Channel Signaling Transmit Multiplexer

This block supplies the outgoing payload bytes for E1 timeslots 15, 16 and 31 while common-channel signaling is switched on. Each of those three timeslots picks its byte from one of two deserialized bus streams: the data stream at the matching channel, or the control stream at a channel that software chooses separately for each timeslot. Bytes are captured as the bus channels go by and held. When the transmit timeslot counter reaches 15, 16 or 31, the held byte for that timeslot is presented with a one-cycle valid strobe.

The bus runs either at 2.048 Mbit/s, with one framer and 32 channels, or at 8.192 Mbit/s. At the faster rate four framers share the bus, and the channels of the four framers are interleaved. The configuration inputs are sampled into an active copy only at the start of each transmit frame. As a result, no output byte is ever built from two different settings.

Top module: `e1ccs_tx`

## Requirements
- R1: After reset, tx_vld_o is 0 and tx_byte_o is 8'hFF. All six held source bytes are 8'hFF. The active configuration has signaling off, all three control-stream selects at 0, 2.048 Mbit/s rate, framer 0 and channel selects 0.
- R2: While the active signaling-mode bit is 0, tx_vld_o stays 0. tx_byte_o only changes in a cycle where tx_vld_o is 1.
- R3: When the active select bit of a timeslot is 0, its byte comes from the data stream at bus channel 15, 16 or 31 (the timeslot's own number). The select bits are bit 0 for timeslot 15, bit 1 for timeslot 16 and bit 2 for timeslot 31.
- R4: When a timeslot's select bit is 1, its byte comes from the control stream at the 5-bit channel programmed for that timeslot (sel15_i, sel16_i, sel31_i). Each timeslot chooses its source on its own, and any mix of the three is allowed.
- R5: The bus channel index used for capture depends on the rate. When rate_hi=0, the index is the timeslot number. When rate_hi=1, it is 4×timeslot+framer, where framer is 0 to 3.
- R6: The bus byte is passed through bit for bit. Bus bit 7 becomes tx_byte_o[7], which is PCM bit 1 and is sent first. Bus bit 0 becomes PCM bit 8.
- R7: The presented byte is the last one captured before the read cycle. A byte arriving in the same cycle as the read is first seen at the next read of that timeslot.
- R8: The configuration inputs take effect only on a cycle with tx_stb_i=1 and tx_ts_i=0. From the following cycle on, they govern both capture and output.
- R9: One cycle after tx_stb_i=1 with tx_ts_i equal to 15, 16 or 31 and signaling active, tx_vld_o=1. This happens in every frame, whatever the CRC-4 multiframe position. In all other cycles tx_vld_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ccs_on_i | input | 1 | Signaling-mode request |
| rate_hi_i | input | 1 | 0: 2.048 Mbit/s bus, 1: 8.192 Mbit/s bus |
| framer_i | input | 2 | Framer number on the shared fast bus |
| use_ctl_i | input | 3 | Per-timeslot control-stream select (bit 0: TS15, bit 1: TS16, bit 2: TS31) |
| sel15_i | input | 5 | Control channel for TS15 |
| sel16_i | input | 5 | Control channel for TS16 |
| sel31_i | input | 5 | Control channel for TS31 |
| dat_vld_i | input | 1 | Data stream byte valid |
| dat_chan_i | input | 7 | Data stream bus channel index |
| dat_byte_i | input | 8 | Data stream byte, bit 7 first on the bus |
| ctl_vld_i | input | 1 | Control stream byte valid |
| ctl_chan_i | input | 7 | Control stream bus channel index |
| ctl_byte_i | input | 8 | Control stream byte |
| tx_stb_i | input | 1 | Transmit timeslot strobe |
| tx_ts_i | input | 5 | Transmit timeslot counter |
| tx_vld_o | output | 1 | Signaling byte valid |
| tx_byte_o | output | 8 | Signaling byte, bit 7 is PCM bit 1 |

## Verification
A wrong held byte shows up as a wrong tx_byte_o at the next strobe for that timeslot. That is no more than one transmit frame after the bad capture. A channel index that is off by a framer offset or by the rate mapping shows up the same way. A configuration that is latched at the wrong time changes the source or the valid pattern within the frame where it was written, and the bench sees that in the next affected slot. A valid strobe that is gated wrongly shows in the cycle after the strobe, because the bench compares the outputs every cycle.

// File: rtl/e1ccs_pkg.sv
package e1ccs_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned TS_W    = 5;
  localparam int unsigned N_FRM   = 4;
  localparam int unsigned FRM_W   = $clog2(N_FRM);
  localparam int unsigned CH_W    = TS_W + FRM_W;
  localparam int unsigned N_SLOT  = 3;
  localparam logic [BYTE_W-1:0] IDLE_BYTE = '1;

  typedef logic [TS_W-1:0] ts_t;
  typedef logic [CH_W-1:0] ch_t;
  typedef logic [BYTE_W-1:0] byte_t;

  typedef struct packed {
    logic                         ccs;
    logic                         rate_hi;
    logic [FRM_W-1:0]             framer;
    logic [N_SLOT-1:0]            use_ctl;
    logic [N_SLOT-1:0][TS_W-1:0]  sel;
  } cfg_t;

  function automatic ts_t slot_ts(input int unsigned idx);
    case (idx)
      0:       return ts_t'(15);
      1:       return ts_t'(16);
      default: return ts_t'(31);
    endcase
  endfunction

  // fast bus interleaves framers: index = N_FRM*ts + framer
  function automatic ch_t bus_chan(input logic rate_hi, input logic [FRM_W-1:0] frm,
                                   input ts_t ts);
    ch_t ch;
    if (rate_hi) ch = {ts, frm};
    else         ch = ch_t'(ts);
    return ch;
  endfunction
endpackage

// File: rtl/e1ccs_cfg_reg.sv
module e1ccs_cfg_reg
  import e1ccs_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  cfg_t   cfg_i,
  input  logic   tx_stb_i,
  input  ts_t    tx_ts_i,
  output cfg_t   cfg_o
);
  logic frame_start;
  cfg_t cfg_q;

  assign frame_start = tx_stb_i && (tx_ts_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cfg_q <= '0;
    else if (frame_start) cfg_q <= cfg_i;
  end

  assign cfg_o = cfg_q;

  p_cfg_frame_only_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_stb_i && tx_ts_i == '0) |=> $stable(cfg_o));
  p_cfg_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_stb_i && tx_ts_i == '0) |=> (cfg_o == $past(cfg_i)));
endmodule

// File: rtl/e1ccs_slot_hold.sv
module e1ccs_slot_hold
  import e1ccs_pkg::*;
#(
  parameter int unsigned SLOT_IDX = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rate_hi_i,
  input  logic [FRM_W-1:0]  framer_i,
  input  ts_t               sel_i,
  input  logic              dat_vld_i,
  input  ch_t               dat_chan_i,
  input  byte_t             dat_byte_i,
  input  logic              ctl_vld_i,
  input  ch_t               ctl_chan_i,
  input  byte_t             ctl_byte_i,
  output byte_t             dat_q_o,
  output byte_t             ctl_q_o
);
  localparam ts_t MY_TS = slot_ts(SLOT_IDX);

  ch_t   dat_src, ctl_src;
  logic  dat_hit, ctl_hit;
  byte_t dat_q, ctl_q;

  assign dat_src = bus_chan(rate_hi_i, framer_i, MY_TS);
  assign ctl_src = bus_chan(rate_hi_i, framer_i, sel_i);
  assign dat_hit = dat_vld_i && (dat_chan_i == dat_src);
  assign ctl_hit = ctl_vld_i && (ctl_chan_i == ctl_src);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dat_q <= IDLE_BYTE;
      ctl_q <= IDLE_BYTE;
    end else begin
      if (dat_hit) dat_q <= dat_byte_i;
      if (ctl_hit) ctl_q <= ctl_byte_i;
    end
  end

  assign dat_q_o = dat_q;
  assign ctl_q_o = ctl_q;

  p_dat_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dat_vld_i |=> $stable(dat_q_o));
  p_ctl_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_vld_i |=> $stable(ctl_q_o));
endmodule

// File: rtl/e1ccs_out_sel.sv
module e1ccs_out_sel
  import e1ccs_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  cfg_t                     cfg_i,
  input  logic                     tx_stb_i,
  input  ts_t                      tx_ts_i,
  input  byte_t [N_SLOT-1:0]       dat_q_i,
  input  byte_t [N_SLOT-1:0]       ctl_q_i,
  output logic                     tx_vld_o,
  output byte_t                    tx_byte_o
);
  logic [N_SLOT-1:0] hit;
  byte_t pick;
  logic  vld_q;
  byte_t byte_q;

  for (genvar s = 0; s < N_SLOT; s++) begin : g_hit
    assign hit[s] = (tx_ts_i == slot_ts(s));
  end

  always_comb begin
    pick = byte_q;
    for (int s = 0; s < N_SLOT; s++) begin
      if (hit[s]) pick = cfg_i.use_ctl[s] ? ctl_q_i[s] : dat_q_i[s];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      byte_q <= IDLE_BYTE;
    end else begin
      vld_q <= tx_stb_i && cfg_i.ccs && (|hit);
      if (tx_stb_i && cfg_i.ccs && (|hit)) byte_q <= pick;
    end
  end

  assign tx_vld_o  = vld_q;
  assign tx_byte_o = byte_q;

  p_slot_onehot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit));
  p_vld_needs_ccs_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_vld_o |-> $past(cfg_i.ccs));
  p_byte_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(tx_byte_o) |-> tx_vld_o);
  p_vld_after_stb_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_vld_o |-> $past(tx_stb_i));
endmodule

// File: rtl/e1ccs_tx.sv
module e1ccs_tx
  import e1ccs_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ccs_on_i,
  input  logic        rate_hi_i,
  input  logic [1:0]  framer_i,
  input  logic [2:0]  use_ctl_i,
  input  logic [4:0]  sel15_i,
  input  logic [4:0]  sel16_i,
  input  logic [4:0]  sel31_i,
  input  logic        dat_vld_i,
  input  logic [6:0]  dat_chan_i,
  input  logic [7:0]  dat_byte_i,
  input  logic        ctl_vld_i,
  input  logic [6:0]  ctl_chan_i,
  input  logic [7:0]  ctl_byte_i,
  input  logic        tx_stb_i,
  input  logic [4:0]  tx_ts_i,
  output logic        tx_vld_o,
  output logic [7:0]  tx_byte_o
);
  cfg_t cfg_in, cfg_act;
  byte_t [N_SLOT-1:0] dat_q, ctl_q;

  always_comb begin
    cfg_in         = '0;
    cfg_in.ccs     = ccs_on_i;
    cfg_in.rate_hi = rate_hi_i;
    cfg_in.framer  = framer_i;
    cfg_in.use_ctl = use_ctl_i;
    cfg_in.sel[0]  = sel15_i;
    cfg_in.sel[1]  = sel16_i;
    cfg_in.sel[2]  = sel31_i;
  end

  e1ccs_cfg_reg u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cfg_i    (cfg_in),
    .tx_stb_i (tx_stb_i),
    .tx_ts_i  (tx_ts_i),
    .cfg_o    (cfg_act)
  );

  for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
    e1ccs_slot_hold #(.SLOT_IDX(s)) u_hold (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .rate_hi_i  (cfg_act.rate_hi),
      .framer_i   (cfg_act.framer),
      .sel_i      (cfg_act.sel[s]),
      .dat_vld_i  (dat_vld_i),
      .dat_chan_i (dat_chan_i),
      .dat_byte_i (dat_byte_i),
      .ctl_vld_i  (ctl_vld_i),
      .ctl_chan_i (ctl_chan_i),
      .ctl_byte_i (ctl_byte_i),
      .dat_q_o    (dat_q[s]),
      .ctl_q_o    (ctl_q[s])
    );
  end

  e1ccs_out_sel u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cfg_i     (cfg_act),
    .tx_stb_i  (tx_stb_i),
    .tx_ts_i   (tx_ts_i),
    .dat_q_i   (dat_q),
    .ctl_q_i   (ctl_q),
    .tx_vld_o  (tx_vld_o),
    .tx_byte_o (tx_byte_o)
  );

  p_vld_slot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_vld_o |-> ($past(tx_ts_i) == 5'd15 || $past(tx_ts_i) == 5'd16 || $past(tx_ts_i) == 5'd31));
endmodule

// File: tb/sim_e1ccs_tx.sv
module sim_e1ccs_tx;
  localparam time TCLK = 10ns;

  logic clk = 0, rst_n = 0;
  logic ccs_on = 0, rate_hi = 0;
  logic [1:0] framer = 0;
  logic [2:0] use_ctl = 0;
  logic [4:0] sel15 = 0, sel16 = 0, sel31 = 0;
  logic dat_vld = 0, ctl_vld = 0, tx_stb = 0;
  logic [6:0] dat_chan = 0, ctl_chan = 0;
  logic [7:0] dat_byte = 0, ctl_byte = 0;
  logic [4:0] tx_ts = 0;
  logic tx_vld;
  logic [7:0] tx_byte;

  int checks = 0, errors = 0;
  string req = "R1";

  // reference state
  int m_ccs = 0, m_rate = 0, m_frm = 0, m_use = 0;
  int m_sel[3] = '{0, 0, 0};
  int m_dat[3] = '{255, 255, 255};
  int m_ctl[3] = '{255, 255, 255};
  int e_vld = 0, e_byte = 255;
  int slots[3] = '{15, 16, 31};

  always #(TCLK/2) clk = ~clk;

  e1ccs_tx u0 (
    .clk_i(clk), .rst_ni(rst_n), .ccs_on_i(ccs_on), .rate_hi_i(rate_hi),
    .framer_i(framer), .use_ctl_i(use_ctl), .sel15_i(sel15), .sel16_i(sel16),
    .sel31_i(sel31), .dat_vld_i(dat_vld), .dat_chan_i(dat_chan),
    .dat_byte_i(dat_byte), .ctl_vld_i(ctl_vld), .ctl_chan_i(ctl_chan),
    .ctl_byte_i(ctl_byte), .tx_stb_i(tx_stb), .tx_ts_i(tx_ts),
    .tx_vld_o(tx_vld), .tx_byte_o(tx_byte)
  );

  task automatic check(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int chan_of(input int ts);
    return m_rate ? ts * 4 + m_frm : ts;
  endfunction

  // one clock: model from pre-edge state, then compare after the edge
  task automatic cyc();
    int nv, nb;
    nv = 0; nb = e_byte;
    for (int s = 0; s < 3; s++)
      if (tx_stb && m_ccs != 0 && tx_ts == slots[s]) begin
        nv = 1;
        nb = ((m_use >> s) & 1) ? m_ctl[s] : m_dat[s];
      end
    for (int s = 0; s < 3; s++) begin
      if (dat_vld && dat_chan == chan_of(slots[s])) m_dat[s] = dat_byte;
      if (ctl_vld && ctl_chan == chan_of(m_sel[s])) m_ctl[s] = ctl_byte;
    end
    if (tx_stb && tx_ts == 0) begin
      m_ccs = ccs_on; m_rate = rate_hi; m_frm = framer; m_use = use_ctl;
      m_sel[0] = sel15; m_sel[1] = sel16; m_sel[2] = sel31;
    end
    e_vld = nv; e_byte = nb;
    @(posedge clk);
    @(negedge clk);
    check(tx_vld, e_vld, "tx_vld_o");
    check(tx_byte, e_byte, "tx_byte_o");
  endtask

  // one transmit frame; div cycles per timeslot, bus channels advance each cycle
  task automatic frame(input int div, input int seed, input bit bus_on);
    for (int k = 0; k < 32 * div; k++) begin
      tx_stb   = (k % div) == 0;
      tx_ts    = 5'((k / div) % 32);
      dat_vld  = bus_on;
      ctl_vld  = bus_on;
      dat_chan = 7'(k % (32 * div));
      ctl_chan = 7'(k % (32 * div));
      dat_byte = 8'(k * 37 + seed);
      ctl_byte = 8'(k * 91 + seed * 3 + 5);
      cyc();
    end
    tx_stb = 0; dat_vld = 0; ctl_vld = 0;
  endtask

  initial begin
    #(TCLK * 100000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    req = "R1";
    check(tx_vld, 0, "reset vld");
    check(tx_byte, 8'hFF, "reset byte");
    rst_n = 1;
    @(negedge clk);

    // R1: idle bytes emitted before any capture
    req = "R1"; ccs_on = 1; frame(1, 0, 0);
    frame(1, 0, 0);
    // R3/R7: data stream, same-cycle arrival seen next frame
    req = "R3_R7"; frame(1, 1, 1);
    frame(1, 2, 1);
    // R4 / R6: mixed sources with custom channels
    req = "R4_R6"; use_ctl = 3'b101; sel15 = 5'd3; sel16 = 5'd20; sel31 = 5'd31;
    frame(1, 3, 1); frame(1, 4, 1); frame(1, 5, 1);
    req = "R4"; use_ctl = 3'b010; sel16 = 5'd0;
    frame(1, 6, 1); frame(1, 7, 1);
    // R5: fast bus, framers 2 and 3
    req = "R5"; rate_hi = 1; framer = 2; use_ctl = 3'b011; sel15 = 5'd9; sel16 = 5'd30;
    frame(4, 8, 1); frame(4, 9, 1);
    framer = 3; frame(4, 10, 1); frame(4, 11, 1);
    // R8: change config mid-frame, effective only from ts 0
    req = "R8"; rate_hi = 0; framer = 0;
    for (int k = 0; k < 20; k++) begin
      tx_stb = 1; tx_ts = 5'(k); dat_vld = 1; ctl_vld = 1;
      dat_chan = 7'(k); ctl_chan = 7'(k); dat_byte = 8'(k + 100); ctl_byte = 8'(k + 200);
      if (k == 10) begin use_ctl = 3'b000; ccs_on = 0; end
      cyc();
    end
    tx_stb = 0; dat_vld = 0; ctl_vld = 0;
    repeat (5) cyc();
    frame(1, 12, 1);
    // R2: signaling off keeps output idle and byte stable
    req = "R2"; frame(1, 13, 1); frame(1, 14, 1);
    // R9: back on, every frame gives three strobes
    req = "R9"; ccs_on = 1; use_ctl = 3'b111; sel15 = 5'd1; sel16 = 5'd2; sel31 = 5'd16;
    for (int f = 0; f < 4; f++) frame(1, 20 + f, 1);
    // R9: strobe with gaps between timeslots
    frame(3, 30, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule